// File: doc/BRIEF.md
# Signed-Amount Shift and Rotate Unit

This block is a purely combinational 16-bit data-movement unit for a small processor datapath. A 2-bit operation select chooses between arithmetic shift, logical shift, rotate, and an upper-byte immediate insert.

The shift amount is a 5-bit two's-complement value. Its sign selects the direction at run time:

- A positive amount moves bits toward the LSB.
- A negative amount moves bits toward the MSB.
- The usable range is -16 to +15.

The unit also reports zero and negative flags for the result. The carry and overflow outputs are tied low so that a condition-code register can take its inputs directly from this block.

Internally, a left move is done by bit-reversing the operand, running it through a right-moving logarithmic barrel, and reversing the result back. One barrel therefore serves both directions and all three movement operations. The insert path bypasses the barrel.

Top module: `shrot_unit`

## Requirements
- R1: With op_i = 2'b00 (arithmetic) and a non-negative amount k, res_o is a_i shifted toward the LSB by k places, with vacated upper bits copied from a_i[15].
- R2: With op_i = 2'b01 (logical) and a non-negative amount k, res_o is a_i shifted toward the LSB by k places, with vacated upper bits set to 0.
- R3: With op_i = 2'b00 or 2'b01 and a negative amount -k, res_o is a_i shifted toward the MSB by k places, with vacated lower bits set to 0. An amount of -16 gives 16'h0000.
- R4: With op_i = 2'b10 (rotate), bits leaving one end re-enter at the other end. A positive amount rolls toward the LSB, a negative amount rolls toward the MSB, and -16 returns a_i unchanged.
- R5: With op_i = 2'b11 (insert), res_o[15:8] equals imm_i and res_o[7:0] equals a_i[7:0], whatever the amount.
- R6: An amount of 0 returns a_i unchanged for the shift and rotate operations.
- R7: z_o is 1 exactly when res_o is 16'h0000.
- R8: n_o equals res_o[15].
- R9: c_o and v_o are always 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | 16 | Operand |
| amt_i | input | 5 | Signed amount; a negative value moves bits toward the MSB |
| imm_i | input | 8 | Byte written into the upper half by the insert operation |
| op_i | input | 2 | 00 arithmetic shift, 01 logical shift, 10 rotate, 11 upper insert |
| res_o | output | 16 | Result |
| z_o | output | 1 | Result is zero |
| n_o | output | 1 | Result bit 15 |
| c_o | output | 1 | Carry, tied low |
| v_o | output | 1 | Overflow, tied low |

## Verification
The bench drives every one of the 32 amounts against every operation. It uses random operands plus the patterns 0x0000, 0x0001, 0x8000 and 0xFFFF. Each result is compared with a bit-by-bit behavioural model.

The corner cases targeted are these:

- **-16 and +15.** A magnitude decoder that mishandles -16 shifts by zero or wraps to +16. It would then return the operand instead of zero for the shifts, or a shifted word for the rotate.
- **Sign fill on arithmetic right shifts of negative operands.** A wrong fill shows up as zeros in the upper bits.
- **Left arithmetic shifts.** A design that replicated the sign bit here would fill the low bits with ones.
- **Insert under non-zero amounts.** This exposes a design that lets the amount leak into the insert path.

The flag outputs are checked on every vector, including all-zero results.

// File: rtl/shrot_pkg.sv
package shrot_pkg;
  typedef enum logic [1:0] {
    OP_ASH = 2'b00,
    OP_LSH = 2'b01,
    OP_ROT = 2'b10,
    OP_INS = 2'b11
  } shrot_op_e;
endpackage

// File: rtl/shrot_amt_dec.sv
module shrot_amt_dec #(
  parameter int AW = 5
) (
  input  logic [AW-1:0] amt_i,
  output logic [AW-1:0] mag_o,
  output logic          left_o
);
  // -2**(AW-1) negates to itself, which read unsigned is the full magnitude
  always_comb begin
    left_o = amt_i[AW-1];
    mag_o  = left_o ? (~amt_i + 1'b1) : amt_i;
  end
endmodule

// File: rtl/shrot_barrel.sv
module shrot_barrel #(
  parameter int W  = 16,
  parameter int SW = 5
) (
  input  logic [W-1:0]  data_i,
  input  logic [SW-1:0] mag_i,
  input  logic          rot_i,
  input  logic          fill_i,
  output logic [W-1:0]  data_o
);
  logic [SW:0][W-1:0] stg;

  assign stg[0] = data_i;

  // stage s moves the word toward the LSB by 2**s places when mag_i[s] is set
  for (genvar s = 0; s < SW; s++) begin : g_stage
    localparam int SH = 2 ** s;
    for (genvar i = 0; i < W; i++) begin : g_bit
      localparam int J = i + SH;
      if (J < W) begin : g_in
        assign stg[s+1][i] = mag_i[s] ? stg[s][J] : stg[s][i];
      end else begin : g_edge
        assign stg[s+1][i] = mag_i[s] ? (rot_i ? stg[s][J % W] : fill_i)
                                      : stg[s][i];
      end
    end
  end

  assign data_o = stg[SW];
endmodule

// File: rtl/shrot_flags.sv
module shrot_flags #(
  parameter int W = 16
) (
  input  logic [W-1:0] res_i,
  output logic         z_o,
  output logic         n_o
);
  assign z_o = ~|res_i;
  assign n_o = res_i[W-1];
endmodule

// File: rtl/shrot_unit.sv
module shrot_unit
  import shrot_pkg::*;
#(
  parameter int W  = 16,
  parameter int AW = 5,
  parameter int IW = 8
) (
  input  logic [W-1:0]  a_i,
  input  logic [AW-1:0] amt_i,
  input  logic [IW-1:0] imm_i,
  input  logic [1:0]    op_i,
  output logic [W-1:0]  res_o,
  output logic          z_o,
  output logic          n_o,
  output logic          c_o,
  output logic          v_o
);
  localparam int LW = W - IW;

  shrot_op_e     op;
  logic [AW-1:0] mag;
  logic          left;
  logic [W-1:0]  fwd, mov, back, res;
  logic          fill;

  assign op = shrot_op_e'(op_i);

  shrot_amt_dec #(.AW(AW)) u_dec (
    .amt_i  (amt_i),
    .mag_o  (mag),
    .left_o (left)
  );

  // left moves reuse the right barrel on a bit-reversed word
  for (genvar i = 0; i < W; i++) begin : g_rev
    assign fwd[i]  = left ? a_i[W-1-i] : a_i[i];
    assign back[i] = left ? mov[W-1-i] : mov[i];
  end

  assign fill = (op == OP_ASH) && !left && a_i[W-1];

  shrot_barrel #(.W(W), .SW(AW)) u_bar (
    .data_i (fwd),
    .mag_i  (mag),
    .rot_i  (op == OP_ROT),
    .fill_i (fill),
    .data_o (mov)
  );

  assign res = (op == OP_INS) ? {imm_i, a_i[LW-1:0]} : back;

  shrot_flags #(.W(W)) u_flg (
    .res_i (res),
    .z_o   (z_o),
    .n_o   (n_o)
  );

  assign res_o = res;
  assign c_o   = 1'b0;
  assign v_o   = 1'b0;
endmodule

// File: rtl/shrot_chk.sv
module shrot_chk #(
  parameter int W  = 16,
  parameter int AW = 5,
  parameter int IW = 8
) (
  input logic [W-1:0]  a_i,
  input logic [AW-1:0] amt_i,
  input logic [IW-1:0] imm_i,
  input logic [1:0]    op_i,
  input logic [W-1:0]  res_o
);
  localparam int LW = W - IW;

  always_comb begin
    // R4
    if (op_i == 2'b10)
      rot_popcount_chk: assert ($countones(res_o) == $countones(a_i));
    // R5
    if (op_i == 2'b11)
      ins_bytes_chk: assert (res_o[LW-1:0] == a_i[LW-1:0] && res_o[W-1:LW] == imm_i);
    // R6
    if (amt_i == '0 && op_i != 2'b11)
      zero_amt_chk: assert (res_o == a_i);
    // R3
    if (op_i[1] == 1'b0 && amt_i == {1'b1, {(AW-1){1'b0}}})
      left_full_chk: assert (res_o == '0);
    // R1
    if (op_i == 2'b00 && !amt_i[AW-1])
      ash_sign_chk: assert (res_o[W-1] == a_i[W-1]);
  end
endmodule

bind shrot_unit shrot_chk #(.W(W), .AW(AW), .IW(IW)) u_chk (
  .a_i   (a_i),
  .amt_i (amt_i),
  .imm_i (imm_i),
  .op_i  (op_i),
  .res_o (res_o)
);

// File: tb/sim_shrot_unit.sv
module sim_shrot_unit;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] a;
  logic [4:0]  amt;
  logic [7:0]  imm;
  logic [1:0]  op;
  logic [15:0] res;
  logic        z, n, c, v;

  int n_vec = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  shrot_unit u0 (
    .a_i   (a),
    .amt_i (amt),
    .imm_i (imm),
    .op_i  (op),
    .res_o (res),
    .z_o   (z),
    .n_o   (n),
    .c_o   (c),
    .v_o   (v)
  );

  function automatic logic [15:0] model(logic [1:0] o, logic [15:0] x,
                                        logic [4:0] am, logic [7:0] im);
    int k = int'($signed(am));
    logic [15:0] y = x;
    if (o == 2'b11) return {im, x[7:0]};
    if (k >= 0) begin
      for (int s = 0; s < k; s++) begin
        case (o)
          2'b00:   y = {y[15], y[15:1]};
          2'b01:   y = {1'b0, y[15:1]};
          default: y = {y[0], y[15:1]};
        endcase
      end
    end else begin
      for (int s = 0; s < -k; s++) begin
        if (o == 2'b10) y = {y[14:0], y[15]};
        else            y = {y[14:0], 1'b0};
      end
    end
    return y;
  endfunction

  function automatic string tag(logic [1:0] o, logic [4:0] am);
    if (am == 5'd0 && o != 2'b11) return "R6";
    case (o)
      2'b00:   return am[4] ? "R3" : "R1";
      2'b01:   return am[4] ? "R3" : "R2";
      2'b10:   return "R4";
      default: return "R5";
    endcase
  endfunction

  task automatic apply(logic [1:0] o, logic [15:0] x, logic [4:0] am, logic [7:0] im);
    logic [15:0] exp_r;
    @(posedge clk);
    op = o; a = x; amt = am; imm = im;
    @(negedge clk);
    exp_r = model(o, x, am, im);
    n_vec++;
    if (res !== exp_r) begin
      n_bad++;
      $display("FAIL %s op=%0d a=%h amt=%0d res=%h exp=%h",
               tag(o, am), o, x, $signed(am), res, exp_r);
    end
    n_vec++;
    if (z !== (exp_r == 16'h0)) begin
      n_bad++;
      $display("FAIL R7 z=%b exp=%b", z, exp_r == 16'h0);
    end
    n_vec++;
    if (n !== exp_r[15]) begin
      n_bad++;
      $display("FAIL R8 n=%b exp=%b", n, exp_r[15]);
    end
    n_vec++;
    if (c !== 1'b0 || v !== 1'b0) begin
      n_bad++;
      $display("FAIL R9 c=%b v=%b exp=0 0", c, v);
    end
  endtask

  initial begin
    op = 2'b00; a = '0; amt = '0; imm = '0;
    repeat (3) @(posedge clk);
    rst_ni = 1'b1;
    // idle inputs: zero result, Z set (R7)
    apply(2'b00, 16'h0000, 5'd0, 8'h00);
    for (int o = 0; o < 4; o++) begin
      for (int k = 0; k < 32; k++) begin
        apply(2'(o), 16'h8000, 5'(k), 8'hA5);
        apply(2'(o), 16'hFFFF, 5'(k), 8'h00);
        apply(2'(o), 16'h0001, 5'(k), 8'h80);
        apply(2'(o), 16'h0000, 5'(k), 8'h3C);
        for (int r = 0; r < 12; r++)
          apply(2'(o), 16'($urandom), 5'(k), 8'($urandom));
      end
    end
    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog act=timeout exp=done");
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule